// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block drives and senses 128 general-purpose pins. The pins are grouped in four banks of 32, and software reaches them over a simple synchronous register bus. Pin index `n` belongs to bank `n >> 5` and sits at bit `n & 31` of that bank's words.

Each bank has the following registers:
- an output latch, changed only through write-1-to-set and write-1-to-clear ports;
- a direction word;
- a level readback;
- rising and falling edge enables;
- a sticky edge-status word;
- two alternate-function words, which are plain storage.

Input pins first pass through a two-flop synchroniser. Edges are then detected by comparing each synchronised sample with the one taken a cycle earlier. Only pins configured as inputs can record an edge.

Three interrupt lines come out of the status words: one for pin 0, one for pin 1, and a shared line for every other pin. While the sleep input is high, a level change on certain input pins raises a one-cycle wake-up request.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is 0. All pins are inputs, `pin_oe` and `pin_out` are 0, all three interrupt lines and `wake_req` are 0, and every register reads 0.
- R2: Banks 0 to 2 use consecutive words at these byte offsets: level 0x000/0x004/0x008, direction 0x00C/0x010/0x014, set 0x018/0x01C/0x020, clear 0x024/0x028/0x02C, rising enable 0x030/0x034/0x038, falling enable 0x03C/0x040/0x044, status 0x048/0x04C/0x050. Bank 3 uses the same registers at 0x100 above bank 0. The alternate-function words alternate low/high per bank from 0x054 up to 0x070. Bank `b` covers pins 32b to 32b+31.
- R3: Writing the set port ORs the written data into the output latch. Reading the set port returns the data last written to it.
- R4: Writing the clear port removes every latch bit written as 1. Zero bits leave the latch unchanged.
- R5: `pin_oe` equals the direction words, where 1 means output. `pin_out` equals the output latch ANDed with direction.
- R6: The level register reads the latch for output pins and the synchronised input for input pins.
- R7: A status bit sets when all of these hold: the synchronised input goes from 0 to 1, the pin is an input, and its rising enable is 1. The bit is visible three clock edges after the pin changes. Output pins never set status.
- R8: Falling edges (1 to 0) set status under the same rule, using the falling enable.
- R9: Writing the status register clears each bit written as 1. If a new edge for a bit lands in the same cycle as its clear, the bit stays set.
- R10: `irq_pin0` follows status bit 0 of bank 0, and `irq_pin1` follows status bit 1 of bank 0. `irq_other` is the OR of all other status bits in all banks.
- R11: While `sleep_in` is 1, a change of the synchronised level on an input pin covered by the fixed wake mask (banks 0 to 3: 0x8003FE1B, 0x002001FC, 0xEC080000, 0x0012007F) pulses `wake_req` for one cycle, three edges after the pin change. Pins outside the mask, output pins, and any pin while `sleep_in` is 0 never raise it.
- R12: Offsets at or above 0x200 read 0 and ignore writes, and unmapped offsets below 0x200 read 0. Reads return data on the clock edge that samples `bus_rd`. The alternate-function words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 128 | Raw pin levels |
| pin_out | output | 128 | Pad output levels |
| pin_oe | output | 128 | Pad output enables |
| sleep_in | input | 1 | Processor is asleep |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Shared interrupt for all other pins |
| wake_req | output | 1 | Wake-up request pulse |

## Verification
A wrong latch or direction bit shows up on `pin_out` or `pin_oe` one edge after the offending write. A decode fault that hits the wrong bank or word shows up on the pads of a different bank, or in a readback value.

A stale edge sample or a misplaced enable shows up three edges after a pin change. It appears either as an interrupt line that fails to rise or as one that rises for an output pin. The clear/edge collision is driven on the exact cycle, so a lost edge is seen as `irq_pin1` dropping. A wrong wake mask or a missing sleep gate is visible as a `wake_req` pulse exactly one cycle long, or as its absence.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BANK_W = 32;
    localparam int NBANK  = 4;

    typedef enum logic [3:0] {
        K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR,
        K_RISE, K_FALL, K_STAT, K_AFLO, K_AFHI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_sel_t;

    // Order of the per-bank register groups in the word map
    function automatic reg_kind_e kind_of(input int idx);
        case (idx)
            0:       return K_LEVEL;
            1:       return K_DIR;
            2:       return K_SET;
            3:       return K_CLR;
            4:       return K_RISE;
            5:       return K_FALL;
            6:       return K_STAT;
            default: return K_NONE;
        endcase
    endfunction

    // Fixed pins that may wake a sleeping processor
    function automatic logic [BANK_W-1:0] wake_mask_of(input int bank);
        case (bank)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    assign synced = sync_q;
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        int a;
        int w;
        int k;
        sel = '{kind: K_NONE, bank: 2'd0};
        a = int'(addr);
        w = a >>> 2;
        k = 0;
        if (a < 'h200) begin
            if (w <= 20) begin
                // three banks per register group, one word each
                sel.kind = kind_of(w / 3);
                sel.bank = 2'(w % 3);
            end else if (w <= 28) begin
                k = w - 21;
                sel.bank = 2'(k >>> 1);
                sel.kind = ((k % 2) == 1) ? K_AFHI : K_AFLO;
            end else if (w >= 64 && w <= 82 && ((w - 64) % 3) == 0) begin
                sel.kind = kind_of((w - 64) / 3);
                sel.bank = 2'd3;
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int               W         = 32,
    parameter logic [W-1:0]     WAKE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sin,
    input  logic         sleep,
    input  logic         wr_en,
    input  reg_kind_e    wr_kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir,
    output logic [W-1:0] olat,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic [W-1:0] status,
    output logic [W-1:0] aflo,
    output logic [W-1:0] afhi,
    output logic [W-1:0] setlast,
    output logic [W-1:0] level,
    output logic         wake_hit
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] olat;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] status;
        logic [W-1:0] aflo;
        logic [W-1:0] afhi;
        logic [W-1:0] setlast;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] edges;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sin;
        edges = ~st_q.dir & ((sin & ~st_q.prev & st_q.rise) |
                             (~sin & st_q.prev & st_q.fall));
        if (wr_en) begin
            case (wr_kind)
                K_DIR:  st_d.dir = wdata;
                K_SET: begin
                    st_d.olat    = st_q.olat | wdata;
                    st_d.setlast = wdata;
                end
                K_CLR:  st_d.olat   = st_q.olat & ~wdata;
                K_RISE: st_d.rise   = wdata;
                K_FALL: st_d.fall   = wdata;
                K_STAT: st_d.status = st_q.status & ~wdata;
                K_AFLO: st_d.aflo   = wdata;
                K_AFHI: st_d.afhi   = wdata;
                default: ;
            endcase
        end
        // a fresh edge overrides a clear in the same cycle
        st_d.status = st_d.status | edges;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir      = st_q.dir;
    assign olat     = st_q.olat;
    assign rise     = st_q.rise;
    assign fall     = st_q.fall;
    assign status   = st_q.status;
    assign aflo     = st_q.aflo;
    assign afhi     = st_q.afhi;
    assign setlast  = st_q.setlast;
    assign level    = (st_q.olat & st_q.dir) | (sin & ~st_q.dir);
    assign wake_hit = sleep & (|((sin ^ st_q.prev) & ~st_q.dir & WAKE_MASK));

    AST_STS_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status) & $past(st_q.dir)) == '0)); // R7

    AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == K_SET) |=> ((st_q.olat & $past(st_q.olat)) == $past(st_q.olat))); // R3

    AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == K_CLR) |=> ((st_q.olat & ~$past(st_q.olat)) == '0)); // R4

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.status & $past(st_q.status)) != '0) |-> $past(wr_en && wr_kind == K_STAT)); // R9
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [BANK_W-1:0]       bus_wdata,
    input  logic                    bus_rd,
    output logic [BANK_W-1:0]       bus_rdata,
    input  logic [NBANK*BANK_W-1:0] pin_in,
    output logic [NBANK*BANK_W-1:0] pin_out,
    output logic [NBANK*BANK_W-1:0] pin_oe,
    input  logic                    sleep_in,
    output logic                    irq_pin0,
    output logic                    irq_pin1,
    output logic                    irq_other,
    output logic                    wake_req
);
    localparam int PINS = NBANK * BANK_W;

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
        logic              wake;
    } top_st_t;

    top_st_t  tq_d, tq_q;
    reg_sel_t sel;
    logic [PINS-1:0]   sync_pins;
    logic [BANK_W-1:0] b_dir    [NBANK];
    logic [BANK_W-1:0] b_olat   [NBANK];
    logic [BANK_W-1:0] b_rise   [NBANK];
    logic [BANK_W-1:0] b_fall   [NBANK];
    logic [BANK_W-1:0] b_stat   [NBANK];
    logic [BANK_W-1:0] b_aflo   [NBANK];
    logic [BANK_W-1:0] b_afhi   [NBANK];
    logic [BANK_W-1:0] b_setl   [NBANK];
    logic [BANK_W-1:0] b_level  [NBANK];
    logic [NBANK-1:0]  b_wake;
    logic [BANK_W-1:0] rmux;
    logic              other;

    gpio_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (sync_pins)
    );

    gpio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic wr_this;
        assign wr_this = bus_wr && (sel.kind != K_NONE) && (int'(sel.bank) == b);

        gpio_bank #(.W(BANK_W), .WAKE_MASK(wake_mask_of(b))) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sin      (sync_pins[b*BANK_W +: BANK_W]),
            .sleep    (sleep_in),
            .wr_en    (wr_this),
            .wr_kind  (sel.kind),
            .wdata    (bus_wdata),
            .dir      (b_dir[b]),
            .olat     (b_olat[b]),
            .rise     (b_rise[b]),
            .fall     (b_fall[b]),
            .status   (b_stat[b]),
            .aflo     (b_aflo[b]),
            .afhi     (b_afhi[b]),
            .setlast  (b_setl[b]),
            .level    (b_level[b]),
            .wake_hit (b_wake[b])
        );

        assign pin_oe [b*BANK_W +: BANK_W] = b_dir[b];
        assign pin_out[b*BANK_W +: BANK_W] = b_olat[b] & b_dir[b];
    end

    always_comb begin
        case (sel.kind)
            K_LEVEL: rmux = b_level[sel.bank];
            K_DIR:   rmux = b_dir[sel.bank];
            K_SET:   rmux = b_setl[sel.bank];
            K_RISE:  rmux = b_rise[sel.bank];
            K_FALL:  rmux = b_fall[sel.bank];
            K_STAT:  rmux = b_stat[sel.bank];
            K_AFLO:  rmux = b_aflo[sel.bank];
            K_AFHI:  rmux = b_afhi[sel.bank];
            default: rmux = '0;
        endcase
    end

    always_comb begin
        other = |(b_stat[0] & ~BANK_W'(3));
        for (int b = 1; b < NBANK; b++) other = other | (|b_stat[b]);
    end

    always_comb begin
        tq_d = tq_q;
        if (bus_rd) tq_d.rdata = rmux;
        tq_d.wake = |b_wake;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tq_q <= '0;
        else        tq_q <= tq_d;
    end

    assign bus_rdata = tq_q.rdata;
    assign wake_req  = tq_q.wake;
    assign irq_pin0  = b_stat[0][0];
    assign irq_pin1  = b_stat[0][1];
    assign irq_other = other;

    AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(sleep_in)); // R11

    AST_FAR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && int'(bus_addr) >= 'h200) |-> (bus_rdata == '0)); // R12
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out, pin_oe;
    logic         sleep_in = 1'b0;
    logic         irq_pin0, irq_pin1, irq_other, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb[$];

    always #4 clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .sleep_in(sleep_in), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
        .irq_other(irq_other), .wake_req(wake_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
    endtask

    // scoreboard monitor: compares registered read data one edge after the strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd === 1'b1) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12 unexpected read actual=%h expected=none", bus_rdata);
                end else begin
                    rd_item_t it;
                    it = sb.pop_front();
                    chk(it.tag, 128'(bus_rdata), 128'(it.exp));
                end
            end
        end
    end

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_sim();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 oe", pin_oe, '0);
        chk("R1 out", pin_out, '0);
        chk("R1 irq", {irq_pin0, irq_pin1, irq_other, wake_req}, '0);
        rd_exp(12'h000, 32'h0, "R1 level");
        rd_exp(12'h00C, 32'h0, "R1 dir");
        rd_exp(12'h048, 32'h0, "R1 status");
        rd_exp(12'h054, 32'h0, "R1 altfn");

        // R5 direction and pad output, R3 set port
        wr(12'h00C, 32'h0000_00F0);
        wr(12'h018, 32'h0000_0FF0);
        chk("R5 oe", pin_oe, 128'h0F0);
        chk("R5 out", pin_out, 128'h0F0);
        rd_exp(12'h018, 32'h0000_0FF0, "R3 set readback");

        // R6 level mux
        pin_in[31:0] = 32'h5;
        repeat (3) tick();
        rd_exp(12'h000, 32'h0000_00F5, "R6 level");

        // R4 clear port
        wr(12'h024, 32'h0000_00F0);
        chk("R4 out cleared", pin_out, '0);
        wr(12'h018, 32'h0000_0010);
        chk("R3 set ors", pin_out, 128'h010);
        rd_exp(12'h018, 32'h0000_0010, "R3 last set");
        wr(12'h024, 32'h0000_0010);
        chk("R4 clear bit4", pin_out, '0);

        // R2 bank 3 and bank 2 mapping
        wr(12'h10C, 32'h1);
        wr(12'h118, 32'h1);
        chk("R2 bank3 pin96", pin_out, 128'h1 << 96);
        wr(12'h014, 32'h8000_0000);
        wr(12'h020, 32'h8000_0000);
        chk("R2 bank2 pin95", pin_out, (128'h1 << 96) | (128'h1 << 95));
        rd_exp(12'h100, 32'h1, "R2 bank3 level");
        rd_exp(12'h010, 32'h0, "R2 bank1 dir");
        rd_exp(12'h064, 32'h0, "R2 bank2 altfn lo");

        // R7 rising edges, inputs only
        wr(12'h030, 32'hFFFF_FFFF);
        wr(12'h03C, 32'h0000_0004);
        pin_in[31:0] = 32'h17;              // bit1 in, bit4 output
        repeat (3) tick();
        chk("R7 irq pin1", {irq_pin0, irq_pin1, irq_other}, 3'b010);
        rd_exp(12'h048, 32'h2, "R7 status bank0");
        wr(12'h034, 32'h0000_0020);
        pin_in[37] = 1'b1;
        repeat (3) tick();
        chk("R10 shared irq", 128'(irq_other), 128'h1);
        rd_exp(12'h04C, 32'h20, "R7 status bank1");

        // R8 falling edge on bit2
        pin_in[2] = 1'b0;
        repeat (3) tick();
        rd_exp(12'h048, 32'h6, "R8 status bank0");

        // R9 write-1-to-clear
        wr(12'h04C, 32'h20);
        wr(12'h048, 32'h4);
        chk("R10 shared irq low", 128'(irq_other), '0);
        rd_exp(12'h048, 32'h2, "R9 status after clear");

        // R9 edge wins over a clear in the same cycle
        pin_in[1] = 1'b0;
        repeat (3) tick();
        wr(12'h048, 32'h2);
        chk("R9 cleared", 128'(irq_pin1), '0);
        pin_in[1] = 1'b1;
        tick();
        tick();
        wr(12'h048, 32'h2);
        chk("R9 edge wins", 128'(irq_pin1), 128'h1);
        wr(12'h048, 32'h2);
        chk("R9 clear after", 128'(irq_pin1), '0);

        // R10 pin 0 line
        pin_in[0] = 1'b0;
        repeat (3) tick();
        pin_in[0] = 1'b1;
        repeat (3) tick();
        chk("R10 irq pin0", {irq_pin0, irq_pin1}, 2'b10);
        wr(12'h048, 32'h1);
        chk("R10 irq pin0 low", 128'(irq_pin0), '0);

        // R11 wake-up
        sleep_in = 1'b1;
        pin_in[0] = 1'b0;
        tick(); tick();
        chk("R11 wake early", 128'(wake_req), '0);
        tick();
        chk("R11 wake pulse", 128'(wake_req), 128'h1);
        tick();
        chk("R11 wake one cycle", 128'(wake_req), '0);
        pin_in[2] = 1'b1;                   // not in mask
        pin_in[4] = 1'b0;                   // in mask but output
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R11 no wake masked", 128'(wake_req), '0);
        end
        sleep_in = 1'b0;
        pin_in[0] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R11 no wake awake", 128'(wake_req), '0);
        end

        // R12 alternate-function words, far and unmapped offsets
        wr(12'h054, 32'hA5A5_0001);
        wr(12'h070, 32'h1234_5678);
        rd_exp(12'h054, 32'hA5A5_0001, "R12 altfn lo");
        rd_exp(12'h070, 32'h1234_5678, "R12 altfn hi");
        wr(12'h20C, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        chk("R12 far write ignored", pin_oe,
            (128'h1 << 96) | (128'h8000_0000 << 64) | 128'hF0);
        rd_exp(12'h200, 32'h0, "R12 far read");
        rd_exp(12'h20C, 32'h0, "R12 far read dir alias");
        rd_exp(12'h0FC, 32'h0, "R12 unmapped read");

        repeat (3) tick();
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12 pending reads actual=%0d expected=0", sb.size());
        end
        finish_sim();
    end
endmodule